// File: doc/BRIEF.md
# Rate-Trimmed Hardware Time Counter

This block keeps a 64-bit time count that advances on each reference tick at a rate that software can trim. A 32-bit rate word sets the speed. On every tick the rate word is added into a 31-bit fractional accumulator, and the whole part of that sum (zero, one or two) is added to the time count. The rate word 0x80000000 stands for exactly nominal speed, which is one count per tick. A signed correction is applied by adding it to that centre value. The supported trim of about ±3.2 % maps to roughly 0.968x to 1.032x, but any 32-bit word is accepted. One count stands for 8 ns of nominal time.

Software loads the rate word or a new absolute time through a write channel. It reads the time through a request/response pair that captures all 64 bits from one cycle. The live count is also driven on a plain output for other timing logic.

The write channel is valid/ready with `wr_ready` tied high, so every write is taken in the cycle its `wr_valid` is high. The read channel holds one response at a time. `rd_req_ready` is low while a response waits, and `rd_rsp_valid` with `rd_rsp_time` stay unchanged until `rd_rsp_ready` is seen high.

Top module: `phc_rate_clock`

## Requirements
- R1: After reset, `time_now` is 0, the rate word is 0x80000000, the fraction is 0, `rd_rsp_valid` is 0, and `rd_req_ready` and `wr_ready` are 1.
- R2: With rate 0x80000000, each cycle with `tick_en` high raises `time_now` by exactly 1 on the next cycle.
- R3: On a tick, the sum of the 31-bit fraction and the rate word is formed. `time_now` rises by that sum divided by 2^31, and the fraction keeps the sum modulo 2^31. For example, 0xC0000000 gives 3 counts per 2 ticks, and 0x40000000 gives 1 count per 2 ticks.
- R4: In a cycle with `tick_en` low and no time load, `time_now` does not change.
- R5: A rate write (`wr_valid`=1, `wr_is_time`=0, rate taken from `wr_data[31:0]`) is used from the next tick on. A tick in the same cycle uses the old rate, and the accumulated fraction is kept.
- R6: A time load (`wr_valid`=1, `wr_is_time`=1) sets `time_now` to `wr_data` on the next cycle and clears the fraction. It wins over a tick in the same cycle.
- R7: A read request accepted in a cycle (`rd_req_valid` and `rd_req_ready` both high) gives `rd_rsp_valid`=1 on the next cycle. `rd_rsp_time` then equals the full 64-bit `time_now` of the accepting cycle, even across a carry from the low to the high 32-bit word.
- R8: While `rd_rsp_valid` is 1 and `rd_rsp_ready` is 0, `rd_rsp_valid` and `rd_rsp_time` hold and `rd_req_ready` is 0. The response clears on the cycle after `rd_rsp_ready` is seen high.
- R9: `wr_ready` is always 1, so a write is never stalled.
- R10: Rate 0xFFFFFFFF never raises the count by more than 2 per tick. Rate 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference tick, one cycle per tick |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_is_time | input | 1 | 0: rate word write, 1: time load |
| wr_data | input | 64 | Rate word in bits 31:0, or the new time |
| rd_req_valid | input | 1 | Read request |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_rsp_valid | output | 1 | Read response present |
| rd_rsp_ready | input | 1 | Read response taken |
| rd_rsp_time | output | 64 | Captured 64-bit time |
| time_now | output | 64 | Live time count |

## Verification
The bench builds the block with its default widths: a 64-bit time count and a 32-bit rate word. The 32-bit rate word puts the exact nominal value and both extreme rates within reach. Time loads just below 2^32 bring the low-to-high word carry into a few ticks, so the atomic read across that carry can be checked. A behavioural model of the count, the fraction and the read slot is compared with the outputs every cycle. The fixed scenarios and a random run of ticks, trims, loads and stalled reads are both checked this way.

// File: rtl/phc_pkg.sv
package phc_pkg;
  // Whole counts gained per tick never exceed 2 (fraction < 1, rate < 2)
  localparam int STEP_W = 2;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic {
    WR_TGT_RATE = 1'b0,
    WR_TGT_TIME = 1'b1
  } wr_target_e;
endpackage

// File: rtl/phc_rate_accum.sv
module phc_rate_accum
  import phc_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear_frac,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_q,
  output step_t             step
);
  localparam int FRAC_W = RATE_W - 1;
  localparam logic [RATE_W-1:0] RATE_NOMINAL = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W-1:0] frac_q;
  logic [RATE_W:0]   sum;

  always_comb begin
    sum  = {2'b00, frac_q} + {1'b0, rate_q};
    step = sum[RATE_W:FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_NOMINAL;
    end else if (rate_wr) begin
      rate_q <= rate_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_frac) begin
      frac_q <= '0;
    end else if (tick) begin
      frac_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/phc_time_counter.sv
module phc_time_counter
  import phc_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  step_t             step,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (load) begin
      time_q <= load_val;
    end else if (tick) begin
      time_q <= time_q + TIME_W'(step);
    end
  end
endmodule

// File: rtl/phc_read_snapshot.sv
module phc_read_snapshot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  input  logic [TIME_W-1:0] time_in,
  output logic [TIME_W-1:0] rsp_time
);
  logic accept;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // All bits captured in one register stage, so both words share a tick
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_time <= '0;
    end else if (accept) begin
      rsp_time <= time_in;
    end
  end
endmodule

// File: rtl/phc_rate_clock.sv
module phc_rate_clock
  import phc_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_is_time,
  input  logic [TIME_W-1:0] wr_data,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [TIME_W-1:0] rd_rsp_time,
  output logic [TIME_W-1:0] time_now
);
  wr_target_e        wr_tgt;
  logic              rate_wr;
  logic              time_ld;
  logic [RATE_W-1:0] rate_q;
  step_t             step;

  assign wr_ready = 1'b1;
  assign wr_tgt   = wr_target_e'(wr_is_time);
  assign rate_wr  = wr_valid && (wr_tgt == WR_TGT_RATE);
  assign time_ld  = wr_valid && (wr_tgt == WR_TGT_TIME);

  phc_rate_accum #(.RATE_W(RATE_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .clear_frac (time_ld),
    .rate_wr    (rate_wr),
    .rate_in    (wr_data[RATE_W-1:0]),
    .rate_q     (rate_q),
    .step       (step)
  );

  phc_time_counter #(.TIME_W(TIME_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .step     (step),
    .load     (time_ld),
    .load_val (wr_data),
    .time_q   (time_now)
  );

  phc_read_snapshot #(.TIME_W(TIME_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .time_in   (time_now),
    .rsp_time  (rd_rsp_time)
  );
endmodule

// File: rtl/phc_rate_clock_chk.sv
module phc_rate_clock_chk #(
  parameter int TIME_W = 64,
  parameter int RATE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_is_time,
  input logic [TIME_W-1:0] wr_data,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic [TIME_W-1:0] rd_rsp_time,
  input logic [TIME_W-1:0] time_now,
  input logic [RATE_W-1:0] rate_q
);
  localparam logic [RATE_W-1:0] RATE_NOMINAL = {1'b1, {(RATE_W-1){1'b0}}};
  logic ld;
  assign ld = wr_valid && wr_is_time;

  // R2
  nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld && rate_q == RATE_NOMINAL) |=> time_now == $past(time_now) + 1);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(time_now));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> time_now == $past(wr_data));

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld) |=> (time_now - $past(time_now)) <= 2);

  // R7
  snapshot_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_rsp_valid && rd_rsp_time == $past(time_now));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> rd_rsp_valid && $stable(rd_rsp_time) && !rd_req_ready);

  // R9
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

bind phc_rate_clock phc_rate_clock_chk #(.TIME_W(TIME_W), .RATE_W(RATE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_is_time   (wr_is_time),
  .wr_data      (wr_data),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_time  (rd_rsp_time),
  .time_now     (time_now),
  .rate_q       (rate_q)
);

// File: tb/test_phc_rate_clock.sv
`timescale 1ns/1ps
module test_phc_rate_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_is_time = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_req_valid = 1'b0;
  logic        rd_req_ready;
  logic        rd_rsp_valid;
  logic        rd_rsp_ready = 1'b1;
  logic [63:0] rd_rsp_time;
  logic [63:0] time_now;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  phc_rate_clock i_phc_rate_clock (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_is_time(wr_is_time), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_time(rd_rsp_time), .time_now(time_now)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [63:0] m_time, m_snap;
  logic [63:0] m_frac;
  logic [31:0] m_rate;
  bit          m_pend;

  always @(posedge clk) begin
    logic [63:0] s;
    logic [63:0] t_old;
    if (!rst_n) begin
      m_time = 0; m_frac = 0; m_rate = 32'h8000_0000; m_pend = 0; m_snap = 0;
    end else begin
      t_old = m_time;
      if (rd_req_valid && !m_pend) begin
        m_pend = 1; m_snap = t_old;
      end else if (m_pend && rd_rsp_ready) begin
        m_pend = 0;
      end
      if (wr_valid && wr_is_time) begin
        m_time = wr_data; m_frac = 0;
      end else if (tick_en) begin
        s = m_frac + {32'd0, m_rate};
        m_time = m_time + (s / 64'h8000_0000);
        m_frac = s % 64'h8000_0000;
      end
      if (wr_valid && !wr_is_time) m_rate = wr_data[31:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "time_now", time_now, m_time);
      check("R8", "rd_rsp_valid", {63'd0, rd_rsp_valid}, {63'd0, m_pend});
      check("R8", "rd_req_ready", {63'd0, rd_req_ready}, {63'd0, !m_pend});
      if (m_pend) check("R7", "rd_rsp_time", rd_rsp_time, m_snap);
    end
  end

  task automatic cyc(input bit t, input bit wv, input bit wt, input logic [63:0] wd, input bit rq);
    tick_en = t; wr_valid = wv; wr_is_time = wt; wr_data = wd; rd_req_valid = rq;
    @(negedge clk);
    tick_en = 0; wr_valid = 0; rd_req_valid = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
  endtask

  task automatic set_rate(input logic [31:0] r, input bit t);
    cyc(t, 1, 0, {32'd0, r}, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "time after reset", time_now, 0);
    check("R1", "rsp_valid after reset", {63'd0, rd_rsp_valid}, 0);
    check("R1", "req_ready after reset", {63'd0, rd_req_ready}, 1);
    // R9
    check("R9", "wr_ready", {63'd0, wr_ready}, 1);

    cur_req = "R2"; ticks(10);
    check("R2", "10 nominal ticks", time_now, 10);

    cur_req = "R4";
    repeat (5) cyc(0, 0, 0, 0, 0);
    check("R4", "no tick holds", time_now, 10);

    cur_req = "R3";
    set_rate(32'hC000_0000, 0); ticks(4);
    check("R3", "1.5 rate x4", time_now, 16);
    set_rate(32'h4000_0000, 0); ticks(3);
    check("R3", "0.5 rate x3", time_now, 17);

    cur_req = "R5";
    set_rate(32'h8000_0000, 1);
    check("R5", "tick uses old rate", time_now, 18);
    set_rate(32'hC000_0000, 0); ticks(1);
    check("R5", "1.5 from zero fraction", time_now, 19);
    set_rate(32'h8000_0000, 0); ticks(1);
    check("R5", "nominal keeps half fraction", time_now, 20);
    set_rate(32'hC000_0000, 0); ticks(1);
    check("R5", "kept fraction adds", time_now, 22);

    cur_req = "R10";
    set_rate(32'hFFFF_FFFF, 0); ticks(1);
    check("R10", "max rate first tick", time_now, 23);
    ticks(1);
    check("R10", "max rate second tick", time_now, 25);
    set_rate(32'h0000_0000, 0); ticks(5);
    check("R10", "zero rate stalls", time_now, 25);

    cur_req = "R6";
    set_rate(32'hC000_0000, 0); ticks(1);
    cyc(1, 1, 1, 64'h1234, 0);
    check("R6", "load beats tick", time_now, 64'h1234);
    ticks(1);
    check("R6", "fraction cleared by load", time_now, 64'h1235);

    cur_req = "R7";
    set_rate(32'h8000_0000, 0);
    cyc(0, 1, 1, 64'h0000_0000_FFFF_FFFF, 0);
    rd_rsp_ready = 0;
    cyc(1, 0, 0, 0, 1);
    check("R7", "snapshot before carry", rd_rsp_time, 64'h0000_0000_FFFF_FFFF);
    check("R7", "live after carry", time_now, 64'h0000_0001_0000_0000);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 0, 1);
      check("R8", "held response", rd_rsp_time, 64'h0000_0000_FFFF_FFFF);
      check("R8", "req blocked", {63'd0, rd_req_ready}, 0);
    end
    rd_rsp_ready = 1;
    cyc(0, 0, 0, 0, 0);
    check("R8", "response released", {63'd0, rd_rsp_valid}, 0);

    cur_req = "R3";
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = $urandom;
      rd_rsp_ready = (r[3:2] != 0);
      if (r[9:4] == 0)
        cyc(r[10], 1, 1, 64'h0000_0002_FFFF_FFF0 + {56'd0, r[23:16]}, r[11]);
      else if (r[9:6] == 1)
        cyc(r[10], 1, 0, {32'd0, 32'h8000_0000 + 32'($signed(r[31:16]) * 1024)}, r[11]);
      else
        cyc(r[1:0] != 0, 0, 0, 0, r[11]);
    end
    rd_rsp_ready = 1;
    cyc(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule